// File: doc/BRIEF.md
# Service Request Status Byte

This block assembles an 8-bit status byte from summary flags produced elsewhere in an instrument's status system. The byte carries the operation summary, the standard event summary, the message-available flag, and four general-purpose summary bits. A software-written enable mask selects which of these bits may raise a service request. The OR of the enabled bits is the master summary, and it is live: it follows the inputs in the same cycle.

A rising master summary sets a request flag. The flag drives the service request output until something clears it. The byte can be read in two ways, and each read returns one byte a cycle later. A status query places the live master summary in bit 6 and changes nothing. A serial poll places the latched request flag in bit 6 and then clears that flag. A clear-status input also drops the flag.

Top module: `srq_status_byte`

## Requirements
- R1: The status byte has this layout. Bits 3..0 come from `low_bits`, bit 4 from `msg_avail`, bit 5 from `event_sum` (weight 32) and bit 7 from `oper_sum` (weight 128). Bit 6 is reserved for the request information.
- R2: `mss` is high in the same cycle whenever any of status bits 0-5 or 7 is high and its enable bit is also set. Enable bit 6 never contributes.
- R3: When `en_we` is high at a clock edge, the enable mask takes the value of `en_wdata`. The new mask governs `mss` from the following cycle.
- R4: When `stat_rd` is high (and `poll_rd` is low) at a clock edge, `rd_valid` is high in the next cycle. In that cycle `rd_data` holds the R1 byte with bit 6 equal to `mss` at the read edge. `srq` is not changed by the query.
- R5: A rise of `mss` while `srq` is low sets `srq` at the next edge, unless a poll or clear occurs in the same cycle. Once set, `srq` stays high until it is cleared.
- R6: When `poll_rd` is high at a clock edge, the next cycle shows `rd_valid` high and `rd_data` holding the R1 byte with bit 6 equal to `srq` before the edge. `srq` is low afterwards. The poll leaves bits other than 6 of later reads unchanged.
- R7: While `mss` stays high after a poll or clear, `srq` is not raised again. `mss` must fall and rise again first.
- R8: When `stat_rd` and `poll_rd` are high in the same cycle, the read behaves as a serial poll.
- R9: `clr_stat` high at an edge leaves `srq` low after that edge, and it wins over a rise of `mss`.
- R10: After reset, `srq` and `rd_valid` are low and the enable mask is zero, so `mss` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| low_bits | input | 4 | General summary bits 3..0 |
| msg_avail | input | 1 | Output queue holds a message (bit 4) |
| event_sum | input | 1 | Standard event summary (bit 5) |
| oper_sum | input | 1 | Operation status summary (bit 7) |
| en_we | input | 1 | Enable mask write strobe |
| en_wdata | input | 8 | Enable mask write value |
| clr_stat | input | 1 | Clear the request flag |
| stat_rd | input | 1 | Status query read |
| poll_rd | input | 1 | Serial-poll read |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 8 | Returned status byte |
| mss | output | 1 | Live master summary |
| srq | output | 1 | Service request (latched flag) |

## Verification
The hardest situation to reach is a poll that returns bit 6 low while the master summary is still high. It only arises after a poll has already cleared the flag and the enabled inputs have been held steady. The bench builds this on purpose: it raises the event summary, polls twice without dropping the input, and then confirms that no new request appears until the input falls and rises again. An exhaustive sweep covers every enable mask against every input pattern for the live summary and the query byte.

// File: rtl/srq_status_byte.sv
module srq_status_byte #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [3:0]   low_bits,
  input  logic         msg_avail,
  input  logic         event_sum,
  input  logic         oper_sum,
  input  logic         en_we,
  input  logic [W-1:0] en_wdata,
  input  logic         clr_stat,
  input  logic         stat_rd,
  input  logic         poll_rd,
  output logic         rd_valid,
  output logic [W-1:0] rd_data,
  output logic         mss,
  output logic         srq
);
  localparam int RQ = 6;
  localparam logic [W-1:0] RQ_MASK = ~(W'(1) << RQ);

  logic [W-1:0] en_q;
  logic [W-1:0] status;
  logic         rqs, mss_q;

  assign status = {oper_sum, 1'b0, event_sum, msg_avail, low_bits};
  assign mss    = |(status & en_q & RQ_MASK);
  assign srq    = rqs;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= '0;
      mss_q    <= 1'b0;
      rqs      <= 1'b0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      if (en_we) en_q <= en_wdata;
      mss_q <= mss;
      if (clr_stat || poll_rd) rqs <= 1'b0;
      else if (mss && !mss_q && !rqs) rqs <= 1'b1;
      rd_valid <= stat_rd | poll_rd;
      if (poll_rd)      rd_data <= {status[7], rqs, status[5:0]};
      else if (stat_rd) rd_data <= {status[7], mss, status[5:0]};
    end
  end
endmodule

module srq_status_byte_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       clr_stat,
  input logic       stat_rd,
  input logic       poll_rd,
  input logic       rd_valid,
  input logic [7:0] rd_data,
  input logic       mss,
  input logic       srq
);
  p_raise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mss) && !srq && !poll_rd && !clr_stat |=> srq);
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    srq && !poll_rd && !clr_stat |=> srq);
  p_query_r4: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd && !poll_rd |=> rd_valid && rd_data[6] == $past(mss));
  p_poll_r6: assert property (@(posedge clk) disable iff (!rst_n)
    poll_rd |=> rd_valid && !srq && rd_data[6] == $past(srq));
  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr_stat |=> !srq);
  p_no_rearm_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !srq && !$rose(mss) |=> !srq);
endmodule

bind srq_status_byte srq_status_byte_chk u_chk (
  .clk(clk), .rst_n(rst_n), .clr_stat(clr_stat), .stat_rd(stat_rd),
  .poll_rd(poll_rd), .rd_valid(rd_valid), .rd_data(rd_data),
  .mss(mss), .srq(srq)
);

// File: tb/srq_status_byte_tb.sv
module srq_status_byte_tb;
  logic clk = 0, rst_n = 0;
  logic [3:0] low_bits = 0;
  logic msg_avail = 0, event_sum = 0, oper_sum = 0;
  logic en_we = 0, clr_stat = 0, stat_rd = 0, poll_rd = 0;
  logic [7:0] en_wdata = 0;
  logic rd_valid, mss, srq;
  logic [7:0] rd_data;
  int errors = 0, checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  srq_status_byte u_dut (.*);

  task automatic chk(string r, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic set_in(logic [6:0] p);
    low_bits = p[3:0]; msg_avail = p[4]; event_sum = p[5]; oper_sum = p[6];
  endtask

  function automatic logic [7:0] raw(logic [6:0] p);
    return {p[6], 1'b0, p[5:0]};
  endfunction

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] exp_b;
    logic m;
    tick(); tick();
    chk("R10 srq", srq, 0); chk("R10 rd_valid", rd_valid, 0); chk("R10 mss", mss, 0);
    rst_n = 1; tick();

    // R1 R2 R3 R4: exhaustive mask x pattern sweep
    clr_stat = 1;
    for (int e = 0; e < 256; e++) begin
      for (int p = 0; p < 128; p++) begin
        en_we = 1; en_wdata = 8'(e); set_in(7'(p)); stat_rd = 0;
        tick();
        en_we = 0; stat_rd = 1;
        m = |(raw(7'(p)) & 8'(e) & 8'hBF);
        chk("R2/R3 mss", mss, m);
        tick();
        exp_b = raw(7'(p)); exp_b[6] = m;
        chk("R1/R4 query byte", {rd_valid, 7'b0} | 8'h00, 8'h80);
        chk("R1/R4 query data", rd_data, exp_b);
        stat_rd = 0;
      end
    end
    clr_stat = 0;

    // R2: enable bit 6 alone never drives mss
    en_we = 1; en_wdata = 8'h40; set_in(7'h7F); tick(); en_we = 0;
    chk("R2 bit6 ignored", mss, 0);

    // R5 R4 R6 R7
    set_in(0); en_we = 1; en_wdata = 8'h20; tick(); en_we = 0; tick();
    chk("R5 idle", srq, 0);
    event_sum = 1; tick();
    chk("R5 raise", srq, 1);
    stat_rd = 1; tick(); stat_rd = 0;
    chk("R4 query bit6", rd_data, 8'h60);
    chk("R4 query keeps srq", srq, 1);
    tick(); chk("R5 holds", srq, 1);
    low_bits = 4'h5; poll_rd = 1; tick(); poll_rd = 0;
    chk("R6 poll data", rd_data, 8'h65);
    chk("R6 poll clears", srq, 0);
    poll_rd = 1; tick(); poll_rd = 0;
    chk("R7 latch vs live", rd_data, 8'h25);
    chk("R7 mss still live", mss, 1);
    tick(); tick(); chk("R7 no rearm", srq, 0);
    stat_rd = 1; tick(); stat_rd = 0;
    chk("R6 other bits intact", rd_data, 8'h65);
    event_sum = 0; tick(); event_sum = 1; tick();
    chk("R7 rearm after fall", srq, 1);

    // R8 both reads
    stat_rd = 1; poll_rd = 1; tick(); stat_rd = 0; poll_rd = 0;
    chk("R8 poll priority data", rd_data, 8'h65);
    chk("R8 poll priority clear", srq, 0);

    // R9 clear status
    event_sum = 0; tick(); event_sum = 1; tick();
    chk("R9 setup", srq, 1);
    clr_stat = 1; tick(); clr_stat = 0;
    chk("R9 clear", srq, 0);
    event_sum = 0; tick();
    event_sum = 1; clr_stat = 1; tick(); clr_stat = 0;
    chk("R9 clear beats rise", srq, 0);
    tick(); chk("R9 no late raise", srq, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule